// File: doc/BRIEF.md
# Time-Shared SECDED Scrubber for Parameter Registers

This block holds a bank of parameter registers and keeps them free of upsets. Each register stores a 22-bit codeword: 16 data bits, 5 Hamming check bits and 1 overall parity bit. A configuration bus delivers each value as two 8-bit slices. The low byte goes into a shared holding register. The high byte then selects a target register, and the encoder writes the complete codeword into it. The data field of every register is always available in parallel on a wide output bus.

A single decoder is shared by all registers instead of one per register. A scrub pointer steps through the bank one register per clock cycle. On each visit the decoder checks the visited word:
- A single-bit error is repaired by writing the corrected word back at the same clock edge.
- A double-bit error leaves the word as it is and raises a sticky flag that names the register.

A host write to the register under visit overrides the scrub write-back. A test input can flip chosen bits of any stored word to model an upset.

Top module: `cfg_scrub_bank`

## Requirements
- R1: Codeword layout: bit 0 is overall even parity over bits 21..1, bits 1, 2, 4, 8 and 16 are Hamming check bits, and data bits 0..15 occupy the remaining positions in ascending order (data bit 0 at position 3, data bit 1 at position 5).
- R2: A write with `wr_hi`=0 only stores `wr_byte` in the shared low holder and changes no data output. A write with `wr_hi`=1 stores the encoded word {`wr_byte`, holder} into register `wr_idx`, visible on `rd_data` after that clock edge. A write with `wr_idx` above NUM_REGS-1 changes nothing.
- R3: After reset all data outputs read 0 and `sec_seen`, `ded_seen` and `ded_idx` are 0.
- R4: The scrub pointer visits one register per clock cycle in ascending order and wraps from NUM_REGS-1 to 0, so a word is checked within NUM_REGS cycles.
- R5: A single data-bit error is corrected by writing back the fixed word at the edge of the visit, and `sec_seen` is set and stays set until reset.
- R6: A single error in the parity bit or in a check bit is also corrected, leaves the data outputs unchanged and does not set `ded_seen`.
- R7: A double-bit error leaves the stored word unchanged, sets `ded_seen` and loads `ded_idx` with the visited register index.
- R8: A high-byte host write to the register visited in the same cycle takes priority over the scrub write-back.
- R9: With `upset_en`=1, `upset_mask` is XORed into register `upset_idx` at the clock edge, after any host or scrub update of that register.
- R10: Once `ded_seen` is set, `ded_idx` keeps the first reported index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Slice write strobe |
| wr_idx | input | 4 | Target register of a high-byte write |
| wr_hi | input | 1 | 1 = high byte (commits the word), 0 = low byte |
| wr_byte | input | 8 | Slice data |
| upset_en | input | 1 | Apply bit-flip mask |
| upset_idx | input | 4 | Register receiving the mask |
| upset_mask | input | 22 | Codeword bits to flip |
| rd_data | output | 192 | Data field of register i at bits [16*i+15:16*i] |
| sec_seen | output | 1 | Sticky: a single error was corrected |
| ded_seen | output | 1 | Sticky: an uncorrectable error was found |
| ded_idx | output | 4 | Register of the first uncorrectable error |

## Verification
A corrupted stored word shows directly on `rd_data`. A single-bit error that the scrubber fails to repair stays visible on that register's data slice longer than NUM_REGS cycles. A pointer that skips registers or steps in the wrong order shows up as a repair that arrives at a cycle other than the one predicted from the register distance. An error left in a parity or check bit cannot be seen on the data outputs. It becomes visible one injection later, when a second flip turns it into a double error and `ded_seen` rises instead of the data being repaired.

// File: rtl/secded22_pkg.sv
`timescale 1ns/1ps
package secded22_pkg;
  localparam int DATA_W = 16;
  localparam int SYN_W  = 5;
  localparam int CW_W   = 22;
  localparam int DIDX_W = $clog2(DATA_W);

  typedef logic [CW_W-1:0]   cw_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [SYN_W-1:0]  syn_t;

  // positions that are powers of two carry Hamming check bits
  function automatic logic is_check_pos(int p);
    return (p & (p - 1)) == 0;
  endfunction

  function automatic cw_t encode(data_t d);
    cw_t cw;
    int  k;
    cw = '0;
    k  = 0;
    for (int p = 1; p < CW_W; p++) begin
      if (!is_check_pos(p)) begin
        cw[p[SYN_W-1:0]] = d[k[DIDX_W-1:0]];
        k++;
      end
    end
    for (int c = 0; c < SYN_W; c++) begin
      logic x;
      int   q;
      x = 1'b0;
      for (int p = 1; p < CW_W; p++) begin
        if (((p >> c) & 1) != 0) x = x ^ cw[p[SYN_W-1:0]];
      end
      q = 1 << c;
      cw[q[SYN_W-1:0]] = x;
    end
    cw[0] = ^cw[CW_W-1:1];
    return cw;
  endfunction

  function automatic syn_t syndrome(cw_t cw);
    syn_t s;
    s = '0;
    for (int p = 1; p < CW_W; p++) begin
      if (cw[p[SYN_W-1:0]]) s = s ^ p[SYN_W-1:0];
    end
    return s;
  endfunction

  function automatic data_t extract(cw_t cw);
    data_t d;
    int    k;
    d = '0;
    k = 0;
    for (int p = 1; p < CW_W; p++) begin
      if (!is_check_pos(p)) begin
        d[k[DIDX_W-1:0]] = cw[p[SYN_W-1:0]];
        k++;
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/scrub_rst_sync.sv
`timescale 1ns/1ps
module scrub_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/secded22_enc.sv
`timescale 1ns/1ps
module secded22_enc
  import secded22_pkg::*;
(
  input  data_t data_i,
  output cw_t   cw_o
);
  assign cw_o = encode(data_i);
endmodule

// File: rtl/secded22_dec.sv
`timescale 1ns/1ps
module secded22_dec
  import secded22_pkg::*;
(
  input  cw_t  cw_i,
  output cw_t  fixed_o,
  output logic single_o,
  output logic double_o
);
  localparam syn_t MAX_POS = SYN_W'(CW_W - 1);

  syn_t syn;
  logic par;

  always_comb begin
    syn      = syndrome(cw_i);
    par      = ^cw_i;
    single_o = par && (syn <= MAX_POS);
    double_o = (!par && (syn != '0)) || (par && (syn > MAX_POS));
    fixed_o  = cw_i;
    for (int p = 0; p < CW_W; p++) begin
      if (single_o && (syn == p[SYN_W-1:0])) fixed_o[p[SYN_W-1:0]] = ~cw_i[p[SYN_W-1:0]];
    end
  end
endmodule

// File: rtl/cfg_scrub_bank.sv
`timescale 1ns/1ps
module cfg_scrub_bank
  import secded22_pkg::*;
#(
  parameter  int NUM_REGS = 12,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic                       wr_hi,
  input  logic [7:0]                 wr_byte,
  input  logic                       upset_en,
  input  logic [IDX_W-1:0]           upset_idx,
  input  logic [CW_W-1:0]            upset_mask,
  output logic [NUM_REGS*DATA_W-1:0] rd_data,
  output logic                       sec_seen,
  output logic                       ded_seen,
  output logic [IDX_W-1:0]           ded_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  logic rst_int_n;

  cw_t              word_q [NUM_REGS];
  cw_t              word_d [NUM_REGS];
  logic [7:0]       lo_q, lo_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             sec_q, sec_d, ded_q, ded_d;
  logic [IDX_W-1:0] didx_q, didx_d;

  cw_t  enc_cw, vis_fixed;
  logic vis_single, vis_double;
  logic host_commit, host_on_visit, upset_ok;

  scrub_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_int_n)
  );

  secded22_enc u_enc (
    .data_i ({wr_byte, lo_q}),
    .cw_o   (enc_cw)
  );

  secded22_dec u_dec (
    .cw_i     (word_q[ptr_q]),
    .fixed_o  (vis_fixed),
    .single_o (vis_single),
    .double_o (vis_double)
  );

  // next-state logic
  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) word_d[i] = word_q[i];
    lo_d   = lo_q;
    sec_d  = sec_q;
    ded_d  = ded_q;
    didx_d = didx_q;
    ptr_d  = (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;

    host_commit   = wr_en && wr_hi && (wr_idx <= LAST_IDX);
    host_on_visit = host_commit && (wr_idx == ptr_q);
    upset_ok      = upset_en && (upset_idx <= LAST_IDX);

    if (wr_en && !wr_hi) lo_d = wr_byte;

    // scrub update, overridden by a host write to the same register
    if (!host_on_visit) begin
      if (vis_single) begin
        word_d[ptr_q] = vis_fixed;
        sec_d         = 1'b1;
      end
      if (vis_double) begin
        ded_d = 1'b1;
        if (!ded_q) didx_d = ptr_q;
      end
    end

    if (host_commit) word_d[wr_idx] = enc_cw;
    if (upset_ok)    word_d[upset_idx] = word_d[upset_idx] ^ upset_mask;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      for (int i = 0; i < NUM_REGS; i++) word_q[i] <= '0;
      lo_q   <= '0;
      ptr_q  <= '0;
      sec_q  <= 1'b0;
      ded_q  <= 1'b0;
      didx_q <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) word_q[i] <= word_d[i];
      lo_q   <= lo_d;
      ptr_q  <= ptr_d;
      sec_q  <= sec_d;
      ded_q  <= ded_d;
      didx_q <= didx_d;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_rd
    assign rd_data[g*DATA_W +: DATA_W] = extract(word_q[g]);
  end

  assign sec_seen = sec_q;
  assign ded_seen = ded_q;
  assign ded_idx  = didx_q;
endmodule

module cfg_scrub_bank_chk
  import secded22_pkg::*;
#(
  parameter int NUM_REGS = 12,
  parameter int IDX_W    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] ptr_q,
  input cw_t              word_q [NUM_REGS],
  input logic             wr_en,
  input logic             wr_hi,
  input logic [IDX_W-1:0] wr_idx,
  input logic             upset_en,
  input logic [IDX_W-1:0] upset_idx,
  input logic             sec_seen,
  input logic             ded_seen,
  input logic [IDX_W-1:0] ded_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);
  localparam syn_t             MAX_POS  = SYN_W'(CW_W - 1);

  logic [IDX_W-1:0] prev_ptr;
  cw_t              prev_word;
  cw_t              vis_word, after_word;
  syn_t             vis_syn;
  logic             vis_par, vis_one, vis_two, quiet, after_clean;

  always_comb begin
    vis_word    = word_q[ptr_q];
    vis_syn     = syndrome(vis_word);
    vis_par     = ^vis_word;
    vis_one     = vis_par && (vis_syn <= MAX_POS);
    vis_two     = !vis_par && (vis_syn != '0);
    quiet       = !(wr_en && wr_hi && (wr_idx == ptr_q)) && !(upset_en && (upset_idx == ptr_q));
    after_word  = word_q[prev_ptr];
    after_clean = (syndrome(after_word) == '0) && !(^after_word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ptr  <= '0;
      prev_word <= '0;
    end else begin
      prev_ptr  <= ptr_q;
      prev_word <= vis_word;
    end
  end

  // R4
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q == LAST_IDX) |=> (ptr_q == '0));

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q != LAST_IDX) |=> (ptr_q == $past(ptr_q) + 1'b1));

  // R5
  fix_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vis_one && quiet) |=> after_clean);

  // R7
  dbl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vis_two && quiet) |=> (after_word == prev_word));

  // R5
  sec_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_seen |=> sec_seen);

  // R10
  ded_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ded_seen |=> (ded_seen && $stable(ded_idx)));
endmodule

bind cfg_scrub_bank cfg_scrub_bank_chk #(
  .NUM_REGS (NUM_REGS),
  .IDX_W    (IDX_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .ptr_q     (ptr_q),
  .word_q    (word_q),
  .wr_en     (wr_en),
  .wr_hi     (wr_hi),
  .wr_idx    (wr_idx),
  .upset_en  (upset_en),
  .upset_idx (upset_idx),
  .sec_seen  (sec_seen),
  .ded_seen  (ded_seen),
  .ded_idx   (ded_idx)
);

// File: tb/cfg_scrub_bank_tb_top.sv
`timescale 1ns/1ps
module cfg_scrub_bank_tb_top;
  localparam int NR = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [3:0]      wr_idx = '0;
  logic            wr_hi = 1'b0;
  logic [7:0]      wr_byte = '0;
  logic            upset_en = 1'b0;
  logic [3:0]      upset_idx = '0;
  logic [21:0]     upset_mask = '0;
  logic [NR*16-1:0] rd_data;
  logic            sec_seen, ded_seen;
  logic [3:0]      ded_idx;

  cfg_scrub_bank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_hi(wr_hi),
    .wr_byte(wr_byte), .upset_en(upset_en), .upset_idx(upset_idx),
    .upset_mask(upset_mask), .rd_data(rd_data), .sec_seen(sec_seen),
    .ded_seen(ded_seen), .ded_idx(ded_idx)
  );

  always #5 clk = ~clk;

  int unsigned edges = 0;
  always @(posedge clk) edges <= edges + 1;
  int unsigned base = 0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] exp_d [NR];

  // {register index, value}
  localparam logic [19:0] VEC [8] = '{
    {4'd0, 16'hA5C3}, {4'd1, 16'h0001}, {4'd2, 16'h8000}, {4'd3, 16'hFFFF},
    {4'd5, 16'h1234}, {4'd7, 16'h00FF}, {4'd11, 16'hBEEF}, {4'd6, 16'h5555}
  };

  function automatic logic [15:0] rd(int r);
    return rd_data[r*16 +: 16];
  endfunction

  // index the design visits at the next rising edge
  function automatic int ph();
    return int'((edges - base) % 12);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic all_match(string req);
    for (int i = 0; i < NR; i++) chk(req, rd(i), exp_d[i]);
  endtask

  task automatic wr_reg(int r, logic [15:0] v);
    wr_en = 1'b1; wr_hi = 1'b0; wr_byte = v[7:0]; wr_idx = 4'(r);
    @(negedge clk);
    wr_hi = 1'b1; wr_byte = v[15:8];
    @(negedge clk);
    wr_en = 1'b0; wr_hi = 1'b0;
  endtask

  task automatic inject(int r, logic [21:0] m);
    upset_en = 1'b1; upset_idx = 4'(r); upset_mask = m;
    @(negedge clk);
    upset_en = 1'b0;
  endtask

  task automatic wait_ph(int v);
    while (ph() != v) @(negedge clk);
  endtask

  // edges after injection until register r reads expv again
  task automatic measure(int r, logic [15:0] expv, output int n);
    n = 0;
    while (rd(r) !== expv && n < 16) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin : main
    int n;
    for (int i = 0; i < NR; i++) exp_d[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 reset state
    all_match("R3 data after reset");
    chk("R3 sec_seen", sec_seen, 0);
    chk("R3 ded_seen", ded_seen, 0);
    chk("R3 ded_idx", ded_idx, 0);

    // R2 / R1 vector table
    for (int v = 0; v < 8; v++) begin
      int r;
      r = int'(VEC[v][19:16]);
      wr_reg(r, VEC[v][15:0]);
      exp_d[r] = VEC[v][15:0];
      chk("R2 loaded value", rd(r), exp_d[r]);
      chk("R2 neighbour", rd((r + 1) % NR), exp_d[(r + 1) % NR]);
    end
    repeat (14) @(negedge clk);
    all_match("R1 clean words untouched by scrub");
    chk("R5 no sec on clean words", sec_seen, 0);

    // R2 low slice alone
    wr_en = 1'b1; wr_hi = 1'b0; wr_byte = 8'h77; wr_idx = 4'd1;
    @(negedge clk);
    wr_en = 1'b0;
    all_match("R2 low slice alone");
    // R2 out-of-range index
    wr_reg(13, 16'hFFFF);
    all_match("R2 index out of range");

    // R9 / R5 / R1 phase discovery on register 0, data bit 0 at position 3
    inject(0, 22'h8);
    chk("R9 upset visible", rd(0), exp_d[0] ^ 16'h1);
    measure(0, exp_d[0], n);
    chk("R4 repaired within 12", (n >= 1 && n <= 12), 1);
    chk("R5 sec_seen set", sec_seen, 1);
    base = edges - 1;

    // R4 wrap: visiting 10 -> 11 -> 0
    wait_ph(10);
    inject(0, 22'h20);
    chk("R1 data bit1 at position 5", rd(0), exp_d[0] ^ 16'h2);
    measure(0, exp_d[0], n);
    chk("R4 wrap distance", n, 2);
    wait_ph(11);
    inject(11, 22'h8);
    measure(11, exp_d[11], n);
    chk("R4 full revisit", n, 12);
    wait_ph(3);
    inject(7, 22'h8);
    measure(7, exp_d[7], n);
    chk("R4 forward distance", n, 4);

    // R6 parity and check bits
    wait_ph(2);
    inject(5, 22'h1);
    chk("R6 parity flip hides data", rd(5), exp_d[5]);
    repeat (13) @(negedge clk);
    inject(5, 22'h10000);
    chk("R6 check flip hides data", rd(5), exp_d[5]);
    repeat (13) @(negedge clk);
    inject(5, 22'h8);
    measure(5, exp_d[5], n);
    chk("R6 later single still repaired", (n >= 1 && n <= 12), 1);
    chk("R6 no ded", ded_seen, 0);

    // R8 host write beats scrub on visited register
    wait_ph(7);
    wr_en = 1'b1; wr_hi = 1'b0; wr_byte = 8'h81; wr_idx = 4'd9;
    @(negedge clk);
    wr_en = 1'b0; upset_en = 1'b1; upset_idx = 4'd9; upset_mask = 22'h8;
    @(negedge clk);
    upset_en = 1'b0; wr_en = 1'b1; wr_hi = 1'b1; wr_byte = 8'h7E;
    @(negedge clk);
    wr_en = 1'b0; wr_hi = 1'b0;
    exp_d[9] = 16'h7E81;
    chk("R8 host value kept", rd(9), exp_d[9]);
    repeat (13) @(negedge clk);
    chk("R8 host value stable", rd(9), exp_d[9]);

    // R7 double error
    wait_ph(4);
    inject(7, 22'h28);
    repeat (14) @(negedge clk);
    chk("R7 double left as is", rd(7), exp_d[7] ^ 16'h3);
    chk("R7 ded_seen", ded_seen, 1);
    chk("R7 ded_idx", ded_idx, 7);

    // R10 first index kept
    inject(2, 22'h28);
    repeat (14) @(negedge clk);
    chk("R10 ded_idx kept", ded_idx, 7);
    chk("R7 second double left", rd(2), exp_d[2] ^ 16'h3);

    // R2 host rewrite repairs a register
    wr_reg(7, 16'hC0DE);
    exp_d[7] = 16'hC0DE;
    repeat (14) @(negedge clk);
    chk("R2 rewrite after double", rd(7), exp_d[7]);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : watchdog
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule